// File: doc/BRIEF.md
# Scanline Access Slot Scheduler

This block paces a video controller's memory port. It counts master clocks across each scan line and lines across each frame. It cuts every line into access slots, which are 16 clocks wide in the wide horizontal mode and 20 clocks wide in the narrow mode. For every slot it decides what the slot is used for:

- a memory refresh slot,
- a slot granted to the external (processor-side) access path, or
- a slot that stays with the display engine.

The rendering fetches themselves are handled elsewhere. This block only withholds the external grant while an active line is being displayed.

On active lines with the display switched off, it also marks the slots at which a run of background-colour pixels is due. The horizontal-mode and PAL/NTSC inputs take effect only at the first clock of each frame. The display-enable input is sampled live at every slot.

Top module: `slot_sched`

## Requirements
- R1: While reset is high, and in the first clock after it, all slot flags are low and both the line number and the slot index are 0.
- R2: A line lasts 3420 master clocks. A slot begins at every clock offset within the line that is a multiple of the slot width (16 in wide mode, 20 in narrow mode). Its index is that offset divided by the width. A wide line therefore holds 214 slots and a narrow line holds 171.
- R3: In wide mode, the slots at indices 73, 105, 137, 169 and 201 are refresh slots, and no other slots are.
- R4: In narrow mode, the slots at indices 66, 98, 130 and 162 are refresh slots, and no other slots are.
- R5: The line number counts up once per line and wraps to 0 after line 261 (NTSC) or line 312 (PAL). The active-line flag is high for lines below 225 (NTSC) or below 241 (PAL).
- R6: A slot that is not a refresh slot is granted to external access when its line is not active or display enable is low. No grant is issued in any other case.
- R7: Background fill is flagged on active lines while display enable is low. In wide mode it applies at slots 55 to 207 in steps of 8. In narrow mode it applies at slots 48 to 168 in steps of 8.
- R8: The mode and PAL inputs are captured only at the first clock of line 0. A change on either input at any other time has no effect until the next frame begins.
- R9: Every output is a register. It shows the decision for the master-clock position of the previous rising edge, using the display-enable value sampled at that edge.
- R10: Refresh, grant and fill are only ever high together with the slot strobe. Between strobes, the slot index holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 1 = 16-clock slots, 0 = 20-clock slots; taken at frame start |
| pal_mode | input | 1 | 1 = PAL line counts, 0 = NTSC; taken at frame start |
| disp_en | input | 1 | Display enable, sampled at every slot |
| slot_stb | output | 1 | One-clock pulse at each slot boundary |
| slot_idx | output | 8 | Index of the slot within the line |
| refresh | output | 1 | Slot is a memory refresh slot |
| ext_grant | output | 1 | Slot is granted to external access |
| bg_fill | output | 1 | Background-colour fill is due at this slot |
| line_num | output | 9 | Current line within the frame |
| active_line | output | 1 | Current line is in the active range |

## Verification
The external grant and the background-fill mark can fall on the same slot. This happens on an active line with the display off, at any fill position that is not a refresh slot. Refresh and fill never coincide.

The bench provokes these overlaps in two ways:
- whole frames in both modes with display enable held low, and
- a frame in which display enable toggles every thousand clocks, so that the overlap appears and disappears in the middle of a line.

Each cycle, the bench compares grant, fill and refresh against a model that works out slot positions and the two sets of slot patterns arithmetically.

// File: rtl/slot_sched_pkg.sv
package slot_sched_pkg;

  // Per-slot decision bundle, registered at the top.
  typedef struct packed {
    logic stb;
    logic refr;
    logic ext;
    logic fill;
  } slot_flags_t;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int min_of(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

endpackage

// File: rtl/slot_pattern.sv
// Matches a slot index against an arithmetic run FIRST, FIRST+STRIDE, ...
module slot_pattern #(
  parameter int SLOT_W = 8,
  parameter int FIRST  = 0,
  parameter int STRIDE = 8,
  parameter int COUNT  = 1
) (
  input  logic [SLOT_W-1:0] idx,
  output logic              hit
);
  logic [COUNT-1:0] match;

  genvar i;
  generate
    for (i = 0; i < COUNT; i++) begin : g_match
      assign match[i] = (idx == SLOT_W'(FIRST + i * STRIDE));
    end
  endgenerate

  assign hit = |match;
endmodule

// File: rtl/slot_line_timer.sv
// Clock / slot / line position counters with frame-start mode capture.
module slot_line_timer #(
  parameter int LINE_CLKS  = 3420,
  parameter int WIDE_DIV   = 16,
  parameter int NARROW_DIV = 20,
  parameter int FRAME_NTSC = 262,
  parameter int FRAME_PAL  = 313,
  parameter int CYC_W      = 12,
  parameter int SUB_W      = 5,
  parameter int SLOT_W     = 8,
  parameter int LINE_W     = 9
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wide_in,
  input  logic              pal_in,
  output logic              at_slot,
  output logic [SLOT_W-1:0] slot_cur,
  output logic [LINE_W-1:0] line_cur,
  output logic              wide_eff,
  output logic              pal_eff
);
  logic [CYC_W-1:0]  cyc_q;
  logic [SUB_W-1:0]  sub_q;
  logic [SLOT_W-1:0] slot_q;
  logic [LINE_W-1:0] line_q;
  logic              wide_q, pal_q;

  logic              frame_start;
  logic              line_end;
  logic [SUB_W-1:0]  div_last;
  logic [LINE_W-1:0] line_last;

  assign frame_start = (cyc_q == '0) && (line_q == '0);
  assign wide_eff    = frame_start ? wide_in : wide_q;
  assign pal_eff     = frame_start ? pal_in  : pal_q;
  assign div_last    = wide_eff ? SUB_W'(WIDE_DIV - 1) : SUB_W'(NARROW_DIV - 1);
  assign line_last   = pal_eff ? LINE_W'(FRAME_PAL - 1) : LINE_W'(FRAME_NTSC - 1);
  assign line_end    = (cyc_q == CYC_W'(LINE_CLKS - 1));

  assign at_slot  = (sub_q == '0);
  assign slot_cur = slot_q;
  assign line_cur = line_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_q  <= '0;
      sub_q  <= '0;
      slot_q <= '0;
      line_q <= '0;
      wide_q <= 1'b0;
      pal_q  <= 1'b0;
    end else begin
      if (frame_start) begin
        wide_q <= wide_in;
        pal_q  <= pal_in;
      end
      if (line_end) begin
        cyc_q  <= '0;
        sub_q  <= '0;
        slot_q <= '0;
        line_q <= (line_q == line_last) ? '0 : line_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
        if (sub_q == div_last) begin
          sub_q  <= '0;
          slot_q <= slot_q + 1'b1;
        end else begin
          sub_q <= sub_q + 1'b1;
        end
      end
    end
  end

  // R2
  sub_bound_chk: assert property (@(posedge clk) disable iff (rst)
    sub_q <= div_last);

  // R5
  line_bound_chk: assert property (@(posedge clk) disable iff (rst)
    line_q <= line_last);

  // R8
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> $stable(wide_q) && $stable(pal_q));
endmodule

// File: rtl/slot_sched.sv
module slot_sched
  import slot_sched_pkg::*;
#(
  parameter int LINE_CLKS   = 3420,
  parameter int WIDE_DIV    = 16,
  parameter int NARROW_DIV  = 20,
  parameter int FRAME_NTSC  = 262,
  parameter int FRAME_PAL   = 313,
  parameter int ACT_NTSC    = 225,
  parameter int ACT_PAL     = 241,
  parameter int REF_STRIDE  = 32,
  parameter int REF_W_FIRST = 73,
  parameter int REF_W_NUM   = 5,
  parameter int REF_N_FIRST = 66,
  parameter int REF_N_NUM   = 4,
  parameter int FILL_STRIDE = 8,
  parameter int FILL_W_FIRST = 55,
  parameter int FILL_W_LAST  = 207,
  parameter int FILL_N_FIRST = 48,
  parameter int FILL_N_LAST  = 168
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       wide_mode,
  input  logic       pal_mode,
  input  logic       disp_en,
  output logic       slot_stb,
  output logic [7:0] slot_idx,
  output logic       refresh,
  output logic       ext_grant,
  output logic       bg_fill,
  output logic [8:0] line_num,
  output logic       active_line
);
  localparam int CYC_W  = $clog2(LINE_CLKS);
  localparam int SUB_W  = $clog2(max_of(WIDE_DIV, NARROW_DIV));
  localparam int SLOT_W = 8;
  localparam int LINE_W = 9;
  localparam int FILL_W_NUM = (FILL_W_LAST - FILL_W_FIRST) / FILL_STRIDE + 1;
  localparam int FILL_N_NUM = (FILL_N_LAST - FILL_N_FIRST) / FILL_STRIDE + 1;

  logic              at_slot;
  logic [SLOT_W-1:0] slot_cur;
  logic [LINE_W-1:0] line_cur;
  logic              wide_eff, pal_eff;
  logic              ref_w, ref_n, fill_w, fill_n;
  logic              ref_hit, fill_hit, act;
  slot_flags_t       flags_d, flags_q;
  logic [SLOT_W-1:0] idx_q;
  logic [LINE_W-1:0] line_q;
  logic              act_q;

  slot_line_timer #(
    .LINE_CLKS(LINE_CLKS), .WIDE_DIV(WIDE_DIV), .NARROW_DIV(NARROW_DIV),
    .FRAME_NTSC(FRAME_NTSC), .FRAME_PAL(FRAME_PAL),
    .CYC_W(CYC_W), .SUB_W(SUB_W), .SLOT_W(SLOT_W), .LINE_W(LINE_W)
  ) u_timer (
    .clk(clk), .rst(rst), .wide_in(wide_mode), .pal_in(pal_mode),
    .at_slot(at_slot), .slot_cur(slot_cur), .line_cur(line_cur),
    .wide_eff(wide_eff), .pal_eff(pal_eff)
  );

  slot_pattern #(.SLOT_W(SLOT_W), .FIRST(REF_W_FIRST), .STRIDE(REF_STRIDE), .COUNT(REF_W_NUM))
    u_ref_w (.idx(slot_cur), .hit(ref_w));
  slot_pattern #(.SLOT_W(SLOT_W), .FIRST(REF_N_FIRST), .STRIDE(REF_STRIDE), .COUNT(REF_N_NUM))
    u_ref_n (.idx(slot_cur), .hit(ref_n));
  slot_pattern #(.SLOT_W(SLOT_W), .FIRST(FILL_W_FIRST), .STRIDE(FILL_STRIDE), .COUNT(FILL_W_NUM))
    u_fill_w (.idx(slot_cur), .hit(fill_w));
  slot_pattern #(.SLOT_W(SLOT_W), .FIRST(FILL_N_FIRST), .STRIDE(FILL_STRIDE), .COUNT(FILL_N_NUM))
    u_fill_n (.idx(slot_cur), .hit(fill_n));

  assign ref_hit  = wide_eff ? ref_w : ref_n;
  assign fill_hit = wide_eff ? fill_w : fill_n;
  assign act      = line_cur < (pal_eff ? LINE_W'(ACT_PAL) : LINE_W'(ACT_NTSC));

  always_comb begin
    flags_d.stb  = at_slot;
    flags_d.refr = at_slot && ref_hit;
    flags_d.ext  = at_slot && !ref_hit && (!act || !disp_en);
    flags_d.fill = at_slot && act && !disp_en && fill_hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags_q <= '0;
      idx_q   <= '0;
      line_q  <= '0;
      act_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      if (at_slot) idx_q <= slot_cur;
      line_q  <= line_cur;
      act_q   <= act;
    end
  end

  assign slot_stb    = flags_q.stb;
  assign refresh     = flags_q.refr;
  assign ext_grant   = flags_q.ext;
  assign bg_fill     = flags_q.fill;
  assign slot_idx    = idx_q;
  assign line_num    = line_q;
  assign active_line = act_q;

  // R10
  flag_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !slot_stb |-> !refresh && !ext_grant && !bg_fill);

  // R2
  strobe_gap_chk: assert property (@(posedge clk) disable iff (rst)
    slot_stb |=> !slot_stb);

  // R5
  line_step_chk: assert property (@(posedge clk) disable iff (rst)
    (line_num != $past(line_num)) |-> slot_stb && (slot_idx == '0));

  // R7
  fill_active_chk: assert property (@(posedge clk) disable iff (rst)
    bg_fill |-> active_line);

  // R6
  grant_refresh_chk: assert property (@(posedge clk) disable iff (rst)
    refresh |-> !ext_grant);
endmodule

// File: tb/tb_slot_sched.sv
module tb_slot_sched;
  localparam int CLK_PERIOD = 10;
  localparam int LCLK = 3420;
  localparam int FR_N = 5, FR_P = 7, AC_N = 3, AC_P = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wide_mode = 1'b1, pal_mode = 1'b1, disp_en = 1'b1;
  logic slot_stb, refresh, ext_grant, bg_fill, active_line;
  logic [7:0] slot_idx;
  logic [8:0] line_num;

  int total = 0, bad = 0;
  int mcyc = 0, mline = 0, prev_idx = 0, line_stbs = 0;
  bit mwide = 0, mpal = 0, line_mismatch = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  slot_sched #(.FRAME_NTSC(FR_N), .FRAME_PAL(FR_P), .ACT_NTSC(AC_N), .ACT_PAL(AC_P)) dut (
    .clk(clk), .rst(rst), .wide_mode(wide_mode), .pal_mode(pal_mode), .disp_en(disp_en),
    .slot_stb(slot_stb), .slot_idx(slot_idx), .refresh(refresh), .ext_grant(ext_grant),
    .bg_fill(bg_fill), .line_num(line_num), .active_line(active_line));

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s at line %0d clk %0d: got %0d exp %0d", tag, mline, mcyc, got, exp);
    end
  endtask

  function automatic bit is_ref(input bit w, input int i);
    if (w) return i >= 73 && i <= 201 && (i - 73) % 32 == 0;
    return i >= 66 && i <= 162 && (i - 66) % 32 == 0;
  endfunction

  function automatic bit is_fill(input bit w, input int i);
    if (w) return i >= 55 && i <= 207 && (i - 55) % 8 == 0;
    return i >= 48 && i <= 168 && (i - 48) % 8 == 0;
  endfunction

  // One master clock: called at a falling edge, returns at the next one.
  task automatic step(input bit w, input bit p, input bit d);
    int div, eidx;
    bit es, act, er, ee, ef;
    wide_mode = w; pal_mode = p; disp_en = d;
    if (mcyc == 0 && mline == 0) begin mwide = w; mpal = p; end
    if (w != mwide || p != mpal) line_mismatch = 1;
    div  = mwide ? 16 : 20;
    es   = (mcyc % div) == 0;
    eidx = es ? mcyc / div : prev_idx;
    act  = mline < (mpal ? AC_P : AC_N);
    er   = es && is_ref(mwide, eidx);
    ee   = es && !er && (!act || !d);
    ef   = es && act && !d && is_fill(mwide, eidx);
    @(posedge clk);
    @(negedge clk);
    check("R9 slot_stb", slot_stb, es);
    check("R2 slot_idx", slot_idx, eidx);
    check(mwide ? "R3 refresh" : "R4 refresh", refresh, er);
    check("R6 ext_grant", ext_grant, ee);
    check("R7 bg_fill", bg_fill, ef);
    check("R5 line_num", line_num, mline);
    check("R5 active_line", active_line, act);
    if (!es) check("R10 quiet flags", refresh | ext_grant | bg_fill, 0);
    prev_idx = eidx;
    if (slot_stb) line_stbs++;
    mcyc++;
    if (mcyc == LCLK) begin
      // count of slots in the finished line
      check(line_mismatch ? "R8 slots per line" : "R2 slots per line",
            line_stbs, mwide ? 214 : 171);
      line_stbs = 0; line_mismatch = 0; mcyc = 0;
      mline = (mline == (mpal ? FR_P : FR_N) - 1) ? 0 : mline + 1;
    end
  endtask

  task automatic run(input int n, input bit w, input bit p, input bit d);
    for (int i = 0; i < n; i++) step(w, p, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: state held in reset
    check("R1 reset stb", slot_stb, 0);
    check("R1 reset flags", refresh | ext_grant | bg_fill, 0);
    check("R1 reset line", line_num, 0);
    check("R1 reset idx", slot_idx, 0);
    rst = 1'b0;
    // Frame 1: wide NTSC, display off; inputs change mid-frame (R8)
    run(8000, 1, 0, 0);
    run(5 * LCLK - 8000, 0, 1, 0);
    // Frame 2: narrow PAL, display on, then off mid-frame
    run(12000, 0, 1, 1);
    run(7 * LCLK - 12000, 1, 0, 0);
    // Frame 3: wide PAL, display enable toggling every 1000 clocks
    for (int k = 0; k < 24; k++) run(k == 23 ? 7 * LCLK - 23000 : 1000, 1, 1, k % 2 == 0);
    // Frame 4: narrow NTSC, display off, wide request ignored
    run(9000, 0, 0, 0);
    run(5 * LCLK - 9000, 1, 0, 0);
    // Start of frame 5 must pick up the wide request
    run(LCLK, 1, 0, 1);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule